// File: doc/BRIEF.md
# Lamp Ballast Sequencing Controller

This block is the synchronous sequencer of a resonant half-bridge lamp inverter. It steps the inverter through four states: reset, ignition, burn and power-down. Its inputs are comparator flags that are already digital: three supply-level flags, two lamp-voltage flags, a flag for the end of the frequency sweep, and a capacitive-mode event. From these it produces the commands for the oscillator, the frequency sweep, the current-regulation loop and the gate drivers. The analog sensing, the oscillator and the current loop sit outside the block.

After the supply passes its start threshold, the controller enables the oscillator, which begins at its highest frequency, and orders a continuous downward sweep. When the lamp voltage first rises above the fail level, an ignition timer counted in clock cycles starts. If the sweep reaches its minimum frequency before the timer expires with the lamp voltage still high, the lamp counts as lit and the controller enters burn, where the regulation loop takes over. If the timer expires while the lamp voltage is still above the fail level, the controller enters a latched power-down. Only a supply collapse below the reset level releases that latch. A lamp that fails during burn sends the controller back to ignition for another attempt.

Transitions: reset to ignition (start), ignition to burn (sweep at minimum), ignition to power-down (timeout with lamp voltage high), burn to ignition (re-ignite), ignition or burn to reset (supply below stop), and power-down to reset (supply below reset level).

Top module: `lamp_ballast_seq`

## Requirements
- R1: The status output `state_code` encodes reset as 3'b000, ignition as 3'b001, burn as 3'b010 and power-down as 3'b100. After `rst_n` is released, the controller is in reset with `drv_off`=1 and every other command output at 0.
- R2: In reset, the controller stays in reset unless `vdd_start`=1 and `vdd_stop`=0 at a clock edge. When both hold, it enters ignition at that edge, and from then `osc_en`=1 and `drv_off`=0.
- R3: In ignition, `sweep_down`=1 while `lv_max`=0. While `lv_max`=1, `volt_limit`=1 and `sweep_down`=0. Neither output is ever 1 outside ignition.
- R4: The ignition timer counts only after `lv_fail` has been seen during ignition. With `lv_fail` low, ignition never times out, however long it lasts.
- R5: If `lv_fail` is 1 from the first clock edge of a run, the controller is still in ignition after IGN_CYCLES-1 edges and is in power-down after IGN_CYCLES edges. This holds for any later `lv_fail` value, provided `lv_fail` is still 1 at the last of those edges. In power-down, `drv_off`=1 and all other command outputs are 0.
- R6: Once started, the timer runs to IGN_CYCLES edges even if `lv_fail` falls. If `lv_fail` is 0 at the expiry edge, the controller stays in ignition and the timer returns to idle, so a later high period again needs a full IGN_CYCLES edges.
- R7: In ignition, `fmin_reached`=1 at an edge without a timeout moves the controller to burn. In burn, `reg_en`=1 and `osc_en`=1, and `reg_en` is 0 in every other state.
- R8: If the timer expires with `lv_fail`=1 at the same edge as `fmin_reached`=1, power-down wins over burn. If `lv_fail`=0 at that edge, the controller enters burn.
- R9: Power-down is latched. `vdd_stop`, `vdd_start`, `lv_fail`, `lv_max`, `fmin_reached` and `cap_mode` have no effect there. Only `vdd_reset`=1 at an edge returns the controller to reset.
- R10: In burn, `lv_fail`=1 at an edge returns the controller to ignition. The timer then starts from zero.
- R11: In ignition or burn, `vdd_stop`=1 at an edge returns the controller to reset with all commands inactive. This takes priority over every other transition.
- R12: In ignition or burn, `fmax_clamp` follows `cap_mode` in the same cycle. In reset or power-down, `fmax_clamp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vdd_start | input | 1 | Supply is above the start threshold |
| vdd_stop | input | 1 | Supply is below the stop threshold |
| vdd_reset | input | 1 | Supply is below the reset level |
| lv_fail | input | 1 | Lamp voltage is above the fail level |
| lv_max | input | 1 | Lamp voltage is above the maximum level |
| fmin_reached | input | 1 | Frequency sweep has reached its minimum |
| cap_mode | input | 1 | Capacitive-mode switching detected |
| osc_en | output | 1 | Oscillator enable |
| sweep_down | output | 1 | Command to keep lowering the frequency |
| reg_en | output | 1 | Average-current regulation loop enable |
| fmax_clamp | output | 1 | Request to jump to and hold the maximum frequency |
| volt_limit | output | 1 | Hold lamp voltage at the maximum level |
| drv_off | output | 1 | Force both bridge switches off |
| state_code | output | 3 | Encoded current state |

## Verification
Two functions can fall on the same clock edge in ignition: the timer expiry and the end of the frequency sweep. The bench sets the timer one edge before expiry and then raises `fmin_reached` at the expiry edge, once with the lamp voltage still above the fail level and once with it below. It judges that the first case ends in power-down and the second in burn. A sweep over how many edges `lv_fail` stays high decides, by simple arithmetic against IGN_CYCLES, whether each run must end in power-down or stay in ignition.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;
    typedef enum logic [2:0] {
        LS_RESET  = 3'b000,
        LS_IGNITE = 3'b001,
        LS_BURN   = 3'b010,
        LS_PWRDN  = 3'b100
    } lamp_state_e;
endpackage

// File: rtl/lamp_ign_timer.sv
module lamp_ign_timer #(
    parameter int IGN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic lv_fail,
    output logic expire
);
    localparam int CW = (IGN_CYCLES > 2) ? $clog2(IGN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IGN_CYCLES - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          counting;

    // Counting starts on the first lamp-voltage excursion and then free-runs
    assign counting = enable && (armed_q || lv_fail);
    assign expire   = counting && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!enable || expire) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (counting) begin
            armed_q <= 1'b1;
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lamp_seq_fsm.sv
module lamp_seq_fsm
    import lamp_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vdd_start,
    input  logic        vdd_stop,
    input  logic        vdd_reset,
    input  logic        lv_fail,
    input  logic        fmin_reached,
    input  logic        ign_expire,
    output lamp_state_e state_q
);
    lamp_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_RESET: begin
                if (vdd_start && !vdd_stop) state_d = LS_IGNITE;
            end
            LS_IGNITE: begin
                if (vdd_stop)                     state_d = LS_RESET;
                else if (ign_expire && lv_fail)   state_d = LS_PWRDN;
                else if (fmin_reached)            state_d = LS_BURN;
            end
            LS_BURN: begin
                if (vdd_stop)     state_d = LS_RESET;
                else if (lv_fail) state_d = LS_IGNITE;
            end
            LS_PWRDN: begin
                if (vdd_reset) state_d = LS_RESET;
            end
            default: state_d = LS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_RESET;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/lamp_seq_outputs.sv
module lamp_seq_outputs
    import lamp_seq_pkg::*;
(
    input  lamp_state_e state_q,
    input  logic        lv_max,
    input  logic        cap_mode,
    output logic        osc_en,
    output logic        sweep_down,
    output logic        reg_en,
    output logic        fmax_clamp,
    output logic        volt_limit,
    output logic        drv_off
);
    always_comb begin
        osc_en     = 1'b0;
        sweep_down = 1'b0;
        reg_en     = 1'b0;
        fmax_clamp = 1'b0;
        volt_limit = 1'b0;
        drv_off    = 1'b1;
        unique case (state_q)
            LS_IGNITE: begin
                osc_en     = 1'b1;
                drv_off    = 1'b0;
                sweep_down = !lv_max;
                volt_limit = lv_max;
                fmax_clamp = cap_mode;
            end
            LS_BURN: begin
                osc_en     = 1'b1;
                drv_off    = 1'b0;
                reg_en     = 1'b1;
                fmax_clamp = cap_mode;
            end
            LS_RESET, LS_PWRDN: begin
                drv_off = 1'b1;
            end
            default: drv_off = 1'b1;
        endcase
    end
endmodule

// File: rtl/lamp_ballast_seq.sv
module lamp_ballast_seq
    import lamp_seq_pkg::*;
#(
    parameter int IGN_CYCLES = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_start,
    input  logic       vdd_stop,
    input  logic       vdd_reset,
    input  logic       lv_fail,
    input  logic       lv_max,
    input  logic       fmin_reached,
    input  logic       cap_mode,
    output logic       osc_en,
    output logic       sweep_down,
    output logic       reg_en,
    output logic       fmax_clamp,
    output logic       volt_limit,
    output logic       drv_off,
    output logic [2:0] state_code
);
    lamp_state_e state_q;
    logic        ign_expire;

    lamp_ign_timer #(.IGN_CYCLES(IGN_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state_q == LS_IGNITE),
        .lv_fail (lv_fail),
        .expire  (ign_expire)
    );

    lamp_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vdd_start    (vdd_start),
        .vdd_stop     (vdd_stop),
        .vdd_reset    (vdd_reset),
        .lv_fail      (lv_fail),
        .fmin_reached (fmin_reached),
        .ign_expire   (ign_expire),
        .state_q      (state_q)
    );

    lamp_seq_outputs u_out (
        .state_q    (state_q),
        .lv_max     (lv_max),
        .cap_mode   (cap_mode),
        .osc_en     (osc_en),
        .sweep_down (sweep_down),
        .reg_en     (reg_en),
        .fmax_clamp (fmax_clamp),
        .volt_limit (volt_limit),
        .drv_off    (drv_off)
    );

    assign state_code = state_q;
endmodule

// File: rtl/lamp_ballast_seq_chk.sv
module lamp_ballast_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_start,
    input logic       vdd_stop,
    input logic       vdd_reset,
    input logic       lv_fail,
    input logic       lv_max,
    input logic       fmin_reached,
    input logic       cap_mode,
    input logic       osc_en,
    input logic       sweep_down,
    input logic       reg_en,
    input logic       fmax_clamp,
    input logic       volt_limit,
    input logic       drv_off,
    input logic [2:0] state_code
);
    localparam logic [2:0] C_RST = 3'b000;
    localparam logic [2:0] C_IGN = 3'b001;
    localparam logic [2:0] C_BRN = 3'b010;
    localparam logic [2:0] C_PDN = 3'b100;

    p_hold_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_RST && !(vdd_start && !vdd_stop)) |=> state_code == C_RST);

    p_limit_stops_sweep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        volt_limit |-> (!sweep_down && state_code == C_IGN));

    p_reg_only_burn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> (state_code == C_BRN && osc_en));

    p_pwrdn_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_PDN && !vdd_reset) |=> state_code == C_PDN);

    p_pwrdn_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_PDN && vdd_reset) |=> state_code == C_RST);

    p_burn_refire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_BRN && lv_fail && !vdd_stop) |=> state_code == C_IGN);

    p_stop_to_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == C_IGN || state_code == C_BRN) && vdd_stop) |=> state_code == C_RST);

    p_clamp_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fmax_clamp |-> (cap_mode && osc_en && !drv_off));

    p_state_onehot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_code));
endmodule

bind lamp_ballast_seq lamp_ballast_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vdd_start    (vdd_start),
    .vdd_stop     (vdd_stop),
    .vdd_reset    (vdd_reset),
    .lv_fail      (lv_fail),
    .lv_max       (lv_max),
    .fmin_reached (fmin_reached),
    .cap_mode     (cap_mode),
    .osc_en       (osc_en),
    .sweep_down   (sweep_down),
    .reg_en       (reg_en),
    .fmax_clamp   (fmax_clamp),
    .volt_limit   (volt_limit),
    .drv_off      (drv_off),
    .state_code   (state_code)
);

// File: tb/lamp_ballast_seq_test.sv
`timescale 1ns/1ps
module lamp_ballast_seq_test;
    localparam int N = 8;
    localparam logic [2:0] S_RST = 3'b000;
    localparam logic [2:0] S_IGN = 3'b001;
    localparam logic [2:0] S_BRN = 3'b010;
    localparam logic [2:0] S_PDN = 3'b100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_start = 0, vdd_stop = 0, vdd_reset = 0;
    logic lv_fail = 0, lv_max = 0, fmin_reached = 0, cap_mode = 0;
    logic osc_en, sweep_down, reg_en, fmax_clamp, volt_limit, drv_off;
    logic [2:0] state_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lamp_ballast_seq #(.IGN_CYCLES(N)) uut (
        .clk(clk), .rst_n(rst_n), .vdd_start(vdd_start), .vdd_stop(vdd_stop),
        .vdd_reset(vdd_reset), .lv_fail(lv_fail), .lv_max(lv_max),
        .fmin_reached(fmin_reached), .cap_mode(cap_mode), .osc_en(osc_en),
        .sweep_down(sweep_down), .reg_en(reg_en), .fmax_clamp(fmax_clamp),
        .volt_limit(volt_limit), .drv_off(drv_off), .state_code(state_code)
    );

    // Expected outputs {osc,sweep,reg,clamp,limit,off} from state and inputs
    function automatic logic [5:0] exp_out(logic [2:0] st, logic lvm, logic cap);
        logic ign, brn;
        ign = (st == S_IGN);
        brn = (st == S_BRN);
        return {ign | brn, ign & ~lvm, brn, (ign | brn) & cap, ign & lvm, ~(ign | brn)};
    endfunction

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_outs(string req);
        chk({2'b0, osc_en, sweep_down, reg_en, fmax_clamp, volt_limit, drv_off},
            {2'b0, exp_out(state_code, lv_max, cap_mode)}, req);
    endtask

    task automatic clear_inputs();
        vdd_start = 0; vdd_stop = 0; vdd_reset = 0;
        lv_fail = 0; lv_max = 0; fmin_reached = 0; cap_mode = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic go_ignite();
        do_reset();
        vdd_start = 1;
        tick(1);
        vdd_start = 0;
    endtask

    task automatic go_burn();
        go_ignite();
        fmin_reached = 1;
        tick(1);
        fmin_reached = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R1: reset state
        do_reset();
        chk({5'b0, state_code}, {5'b0, S_RST}, "R1 state after reset");
        chk({2'b0, osc_en, sweep_down, reg_en, fmax_clamp, volt_limit, drv_off},
            8'b0000_0001, "R1 outputs after reset");

        // R2: no start while stop flag set or start flag low
        vdd_start = 1; vdd_stop = 1;
        tick(3);
        chk({5'b0, state_code}, {5'b0, S_RST}, "R2 held by stop flag");
        vdd_start = 0; vdd_stop = 0;
        tick(3);
        chk({5'b0, state_code}, {5'b0, S_RST}, "R2 held without start");
        vdd_start = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_IGN}, "R2 start to ignition");
        chk({6'b0, osc_en, drv_off}, 8'b10, "R2 oscillator on drivers live");

        // R3 / R12: output sweep over lv_max x cap_mode in every state
        for (int st = 0; st < 4; st++) begin
            case (st)
                0: do_reset();
                1: go_ignite();
                2: go_burn();
                default: begin
                    go_ignite(); lv_fail = 1; tick(N); lv_fail = 0;
                end
            endcase
            for (int c = 0; c < 4; c++) begin
                lv_max = c[0]; cap_mode = c[1];
                #1;
                chk_outs("R3 R12 output decode");
            end
            lv_max = 0; cap_mode = 0;
            tick(1);
        end

        // R4: no timeout without lv_fail
        go_ignite();
        tick(5 * N);
        chk({5'b0, state_code}, {5'b0, S_IGN}, "R4 no timeout while lamp low");

        // R5 / R6: sweep of lv_fail high duration d
        for (int d = 1; d <= N + 2; d++) begin
            go_ignite();
            lv_fail = 1;
            for (int k = 1; k <= N + 2; k++) begin
                tick(1);
                if (k == d) lv_fail = 0;
                if (k == N - 1)
                    chk({5'b0, state_code}, {5'b0, S_IGN}, "R5 still ignition before expiry");
                if (k == N)
                    chk({5'b0, state_code}, {5'b0, (d >= N) ? S_PDN : S_IGN},
                        "R5 R6 state at expiry edge");
            end
            if (d >= N) begin
                chk_outs("R5 power-down outputs");
                chk({6'b0, osc_en, drv_off}, 8'b01, "R5 drivers off in power-down");
            end else begin
                // R6: timer idle again, a fresh run needs the full count
                lv_fail = 1;
                tick(N - 1);
                chk({5'b0, state_code}, {5'b0, S_IGN}, "R6 fresh run before expiry");
                tick(1);
                chk({5'b0, state_code}, {5'b0, S_PDN}, "R6 fresh run expiry");
                lv_fail = 0;
            end
        end

        // R7: minimum frequency to burn
        go_ignite();
        fmin_reached = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_BRN}, "R7 enter burn");
        chk({6'b0, reg_en, osc_en}, 8'b11, "R7 regulation enabled");

        // R8: expiry and minimum frequency on the same edge
        go_ignite();
        lv_fail = 1;
        tick(N - 1);
        fmin_reached = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_PDN}, "R8 timeout beats burn");
        go_ignite();
        lv_fail = 1;
        tick(1);
        lv_fail = 0;
        tick(N - 2);
        chk({5'b0, state_code}, {5'b0, S_IGN}, "R8 armed, one edge left");
        fmin_reached = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_BRN}, "R8 expiry with lamp low goes burn");

        // R9: power-down latch
        go_ignite();
        lv_fail = 1;
        tick(N);
        clear_inputs();
        vdd_stop = 1; vdd_start = 1; lv_fail = 1; lv_max = 1;
        fmin_reached = 1; cap_mode = 1;
        tick(4);
        chk({5'b0, state_code}, {5'b0, S_PDN}, "R9 latched under all inputs");
        chk({2'b0, osc_en, sweep_down, reg_en, fmax_clamp, volt_limit, drv_off},
            8'b0000_0001, "R9 outputs stay off");
        clear_inputs();
        vdd_reset = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_RST}, "R9 release to reset");
        vdd_reset = 0; vdd_start = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_IGN}, "R9 restart after release");

        // R10: lamp failure in burn re-ignites with fresh timer
        go_burn();
        lv_fail = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_IGN}, "R10 burn back to ignition");
        chk({7'b0, reg_en}, 8'b0, "R10 regulation off");
        tick(N - 1);
        chk({5'b0, state_code}, {5'b0, S_IGN}, "R10 timer fresh before expiry");
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_PDN}, "R10 timeout after re-ignite");

        // R11: supply stop in ignition and burn
        go_ignite();
        lv_fail = 1; fmin_reached = 1; vdd_stop = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_RST}, "R11 stop from ignition");
        chk({2'b0, osc_en, sweep_down, reg_en, fmax_clamp, volt_limit, drv_off},
            8'b0000_0001, "R11 outputs inactive");
        go_burn();
        lv_fail = 1; vdd_stop = 1;
        tick(1);
        chk({5'b0, state_code}, {5'b0, S_RST}, "R11 stop from burn");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule